// File: doc/BRIEF.md
# Request-Driven Serial Slave Result Port

This block returns a 16-bit measurement result to a host over a clocked serial slave link, and only when the host asks for one. The host holds an active-low request line low for a minimum time. The block then emits a one-cycle acquisition start pulse to the measurement engine and waits for that engine to report completion along with its data word.

If the host has released the request by the time the result arrives, the block starts driving two lines. It pulls its active-low data-ready line low and puts the most significant result bit on the serial data line. The host then clocks the word out with SCK, upper byte first and MSB first, and it may pause for any length of time between the two bytes. When the last bit has been sampled, both lines are released to float.

If the request is still held low when the result arrives, the block does not return data. It enters a setup mode and stays there until reset. A static polarity input selects the SCK idle level and therefore which SCK edge is the launching edge. SCK is a slow, asynchronous input; the request line is also asynchronous. Both are resynchronised to the system clock.

Top module: `req_spi_slave`

## Requirements
- R1: After reset, sdo_oe and drdy_oe are 0, drdy_n is 1, setup_mode is 0 and acq_start is 0.
- R2: A request (req_n = 0) held for at least REQ_MIN_CYCLES system clocks after synchronisation produces exactly one acq_start pulse. A request shorter than REQ_MIN_CYCLES - 2 clocks produces none.
- R3: When acq_done arrives with the request released, drdy_n goes to 0 and drdy_oe and sdo_oe go to 1 in the same cycle, and sdo already carries bit 15 of acq_data before any SCK edge.
- R4: When acq_done arrives while req_n is still 0, setup_mode becomes 1 and stays 1 until reset. drdy_oe and sdo_oe stay 0, and later requests give no acq_start.
- R5: With sck_idle_high = 0, the launching edge is the rising SCK edge and the sampling edge is the falling edge. With sck_idle_high = 1, the two edges swap. sdo changes only on a launching edge, and the first launching edge of a transfer keeps bit 15.
- R6: The word goes out high byte first and MSB first: after launching edge n (n = 0..15), sdo equals bit 15-n of the captured word.
- R7: A pause of any length between the 8th sampling edge and the 9th launching edge leaves sdo at bit 8 and does not lose the bit position.
- R8: At the 16th sampling edge, drdy_oe and sdo_oe return to 0 and drdy_n to 1.
- R9: A request of any length made while data-ready is asserted is ignored: no acq_start, and the word being shifted is not disturbed.
- R10: SCK edges while no transfer is in progress are ignored: the next transfer still starts at bit 15.
- R11: acq_done while no acquisition is pending is ignored: drdy_oe and sdo_oe stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 1 | Asynchronous active-low acquisition request |
| sck | input | 1 | Asynchronous serial clock from the host |
| sck_idle_high | input | 1 | Polarity select: 0 idle low, launch on rise; 1 idle high, launch on fall |
| acq_start | output | 1 | One-cycle pulse that starts an acquisition |
| acq_done | input | 1 | One-cycle pulse marking the result valid |
| acq_data | input | 16 | Acquisition result, sampled with acq_done |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Drive enable for sdo; 0 means floating |
| drdy_n | output | 1 | Active-low data-ready value |
| drdy_oe | output | 1 | Drive enable for drdy_n; 0 means floating (pulled high) |
| setup_mode | output | 1 | Set when the request outlasted the acquisition |

## Verification
The bench tests the request length on both sides of the threshold. A design that counted unsynchronised or overlapping lows would fire on a short pulse or fire twice on a long one. It runs random words in both polarities with random pauses between bytes. A design that shifted on the sampling edge, or on the first launching edge, would return the word shifted by one bit, and a design that reset its bit position in the pause would repeat the upper byte. Further directed cases cover three situations: a request made during a transfer, stray SCK toggles and completion pulses while idle, and a request held through completion. A design that got these wrong would start a second acquisition, begin the next word mid-stream, drive data-ready without a request, or return data instead of entering setup mode.

// File: rtl/req_spi_pkg.sv
package req_spi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACQ   = 2'd1,
        ST_XFER  = 2'd2,
        ST_SETUP = 2'd3
    } port_state_t;

    typedef struct packed {
        logic launch;
        logic sample;
    } sck_edges_t;

    function automatic sck_edges_t classify_edges(input logic prev,
                                                  input logic cur,
                                                  input logic idle_high);
        sck_edges_t e;
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = prev & ~cur;
        e.launch = idle_high ? fall : rise;
        e.sample = idle_high ? rise : fall;
        return e;
    endfunction

endpackage

// File: rtl/req_spi_sync.sv
module req_spi_sync #(
    parameter int          STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/req_spi_ctrl.sv
module req_spi_ctrl
    import req_spi_pkg::*;
#(
    parameter int REQ_MIN_CYCLES = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic req_s,
    input  logic acq_done,
    input  logic xfer_done,
    output logic acq_start,
    output logic load,
    output logic xfer_active,
    output logic setup_mode
);
    localparam int RC_W = $clog2(REQ_MIN_CYCLES + 1);

    port_state_t     state;
    logic [RC_W-1:0] low_cnt;

    assign load        = (state == ST_ACQ) && acq_done && req_s;
    assign xfer_active = (state == ST_XFER);
    assign setup_mode  = (state == ST_SETUP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            low_cnt   <= '0;
            acq_start <= 1'b0;
        end else begin
            acq_start <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (!req_s) begin
                        if (low_cnt == RC_W'(REQ_MIN_CYCLES - 1)) begin
                            acq_start <= 1'b1;
                            low_cnt   <= '0;
                            state     <= ST_ACQ;
                        end else begin
                            low_cnt <= low_cnt + 1'b1;
                        end
                    end else begin
                        low_cnt <= '0;
                    end
                end
                ST_ACQ: begin
                    low_cnt <= '0;
                    if (acq_done) state <= req_s ? ST_XFER : ST_SETUP;
                end
                ST_XFER: begin
                    low_cnt <= '0;
                    if (xfer_done) state <= ST_IDLE;
                end
                default: begin
                    low_cnt <= '0;
                    state   <= ST_SETUP;
                end
            endcase
        end
    end

    // R2: a start pulse follows a low synchronised request
    a_r2_start_needs_req: assert property (@(posedge clk) disable iff (rst)
        acq_start |-> $past(!req_s));

    // R4: setup entry only on completion while the request is held
    a_r4_setup_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(setup_mode) |-> ($past(acq_done) && $past(!req_s)));

    // R4: setup mode is sticky
    a_r4_setup_sticky: assert property (@(posedge clk) disable iff (rst)
        setup_mode |=> setup_mode);

    // R3: data-ready asserts only on an acquisition completion
    a_r3_ready_after_done: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_active) |-> $past(acq_done));
endmodule

// File: rtl/req_spi_shifter.sv
module req_spi_shifter
    import req_spi_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_s,
    input  logic              idle_high,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              active,
    output logic              sdo_bit,
    output logic              done
);
    localparam int CNT_W = $clog2(DATA_W);

    logic              sck_prev;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  samp_cnt;
    sck_edges_t        ev;

    assign ev      = classify_edges(sck_prev, sck_s, idle_high);
    assign sdo_bit = shreg[DATA_W-1];
    assign done    = active && ev.sample && (samp_cnt == CNT_W'(DATA_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev <= 1'b0;
            shreg    <= '0;
            samp_cnt <= '0;
        end else begin
            sck_prev <= sck_s;
            if (load) begin
                shreg    <= load_data;
                samp_cnt <= '0;
            end else if (active) begin
                if (ev.launch && (samp_cnt != '0))
                    shreg <= {shreg[DATA_W-2:0], 1'b0};
                if (ev.sample)
                    samp_cnt <= samp_cnt + 1'b1;
            end
        end
    end

    // R7: the shift register only moves on a load or a launching edge
    a_r7_hold_between_edges: assert property (@(posedge clk) disable iff (rst)
        (!load && !ev.launch) |=> $stable(shreg));
endmodule

// File: rtl/req_spi_slave.sv
module req_spi_slave
    import req_spi_pkg::*;
#(
    parameter int REQ_MIN_CYCLES = 30,
    parameter int DATA_W         = 16,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_n,
    input  logic              sck,
    input  logic              sck_idle_high,
    output logic              acq_start,
    input  logic              acq_done,
    input  logic [DATA_W-1:0] acq_data,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              drdy_n,
    output logic              drdy_oe,
    output logic              setup_mode
);
    logic req_s;
    logic sck_s;
    logic load;
    logic xfer_active;
    logic xfer_done;
    logic sdo_bit;

    req_spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
        .clk(clk), .rst(rst), .din(req_n), .dout(req_s)
    );

    req_spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst(rst), .din(sck), .dout(sck_s)
    );

    req_spi_ctrl #(.REQ_MIN_CYCLES(REQ_MIN_CYCLES)) u_ctrl (
        .clk(clk), .rst(rst), .req_s(req_s), .acq_done(acq_done),
        .xfer_done(xfer_done), .acq_start(acq_start), .load(load),
        .xfer_active(xfer_active), .setup_mode(setup_mode)
    );

    req_spi_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .sck_s(sck_s), .idle_high(sck_idle_high),
        .load(load), .load_data(acq_data), .active(xfer_active),
        .sdo_bit(sdo_bit), .done(xfer_done)
    );

    assign drdy_oe = xfer_active;
    assign drdy_n  = ~xfer_active;
    assign sdo_oe  = xfer_active;
    assign sdo     = xfer_active ? sdo_bit : 1'b0;

    // R8: lines are released only at the final sampling edge
    a_r8_release_on_last: assert property (@(posedge clk) disable iff (rst)
        $fell(drdy_oe) |-> $past(xfer_done));

    // R4: nothing is driven in setup mode
    a_r4_float_in_setup: assert property (@(posedge clk) disable iff (rst)
        setup_mode |-> (!sdo_oe && !drdy_oe));
endmodule

// File: tb/req_spi_slave_tb.sv
module req_spi_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int REQ_MIN    = 30;
    localparam int HALF       = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_n = 1'b1;
    logic        sck = 1'b0;
    logic        sck_idle_high = 1'b0;
    logic        acq_start;
    logic        acq_done = 1'b0;
    logic [15:0] acq_data = '0;
    logic        sdo, sdo_oe, drdy_n, drdy_oe, setup_mode;

    int checks = 0;
    int failures = 0;
    int starts = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    req_spi_slave dut_i (
        .clk(clk), .rst(rst), .req_n(req_n), .sck(sck),
        .sck_idle_high(sck_idle_high), .acq_start(acq_start),
        .acq_done(acq_done), .acq_data(acq_data), .sdo(sdo),
        .sdo_oe(sdo_oe), .drdy_n(drdy_n), .drdy_oe(drdy_oe),
        .setup_mode(setup_mode)
    );

    always @(posedge clk) if (!rst && acq_start) starts <= starts + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic expected_bit(input logic [15:0] w, input int n);
        return w[15-n];
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(2);
    endtask

    task automatic set_idle(input logic pol);
        sck_idle_high = pol;
        sck = pol;
        wait_clk(6);
    endtask

    // request, acquisition and completion; hold keeps the request low
    task automatic acquire(input logic [15:0] d, input bit hold);
        int s0;
        s0 = starts;
        req_n = 1'b0;
        wait_clk(REQ_MIN + 6);
        check("R2 one start on long request", starts, s0 + 1);
        if (!hold) req_n = 1'b1;
        wait_clk(5);
        acq_data = d;
        acq_done = 1'b1;
        wait_clk(1);
        acq_done = 1'b0;
        acq_data = ~d;
        wait_clk(1);
    endtask

    task automatic transfer(input logic [15:0] exp, input int gap, input bit req_mid);
        logic [15:0] got;
        logic pol;
        int s0;
        pol = sck_idle_high;
        got = '0;
        check("R3 data-ready low", {drdy_oe, drdy_n, sdo_oe}, 3'b101);
        check("R3 first bit before clock", sdo, exp[15]);
        for (int n = 0; n < 16; n++) begin
            sck = ~pol;
            wait_clk(HALF);
            got[15-n] = sdo;
            if (sdo !== expected_bit(exp, n)) begin
                checks++; failures++;
                $display("FAIL R5 bit %0d actual=%0h expected=%0h", n, sdo, expected_bit(exp, n));
            end
            sck = pol;
            wait_clk(HALF);
            if (n == 7) begin
                s0 = starts;
                if (req_mid) begin
                    req_n = 1'b0;
                    wait_clk(REQ_MIN + 10);
                    req_n = 1'b1;
                    wait_clk(4);
                    check("R9 no start during transfer", starts, s0);
                end
                wait_clk(gap);
                check("R7 bit 8 held in gap", sdo, exp[8]);
                check("R7 still driving in gap", drdy_oe, 1'b1);
            end
            if (n == 14) check("R8 still driven before last", drdy_oe, 1'b1);
        end
        wait_clk(2);
        check("R6 word order", got, exp);
        check("R8 released", {drdy_oe, drdy_n, sdo_oe}, 3'b010);
    endtask

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        // R1
        check("R1 reset outputs", {sdo_oe, drdy_oe, drdy_n, setup_mode, acq_start}, 5'b00100);

        // R2 short request
        begin
            int s0;
            s0 = starts;
            req_n = 1'b0;
            wait_clk(REQ_MIN - 3);
            req_n = 1'b1;
            wait_clk(10);
            check("R2 short request ignored", starts, s0);
            check("R2 short request no ready", drdy_oe, 1'b0);
        end

        // R11 stray completion
        acq_data = 16'hFFFF;
        acq_done = 1'b1; wait_clk(1); acq_done = 1'b0;
        wait_clk(3);
        check("R11 stray done ignored", {drdy_oe, sdo_oe}, 2'b00);

        // directed transfers, both polarities
        set_idle(1'b0);
        acquire(16'hA55A, 0);
        transfer(16'hA55A, 0, 0);
        set_idle(1'b1);
        acquire(16'h8001, 0);
        transfer(16'h8001, 30, 0);

        // R10 stray SCK toggles while idle, then a transfer
        for (int k = 0; k < 5; k++) begin
            sck = ~sck; wait_clk(HALF);
        end
        set_idle(1'b0);
        acquire(16'h7FFE, 0);
        check("R10 starts at bit 15", sdo, 1'b0);
        transfer(16'h7FFE, 5, 0);

        // R9 request during transfer
        set_idle(1'b1);
        acquire(16'h3C96, 0);
        transfer(16'h3C96, 10, 1);

        // random words, polarity and pauses
        for (int it = 0; it < 8; it++) begin
            logic [15:0] w;
            w = 16'($urandom);
            set_idle(1'($urandom));
            acquire(w, 0);
            transfer(w, int'($urandom % 40), 0);
        end

        // R4 request held through completion
        acquire(16'h1234, 1);
        check("R4 setup entered", setup_mode, 1'b1);
        check("R4 nothing driven", {drdy_oe, sdo_oe}, 2'b00);
        req_n = 1'b1;
        wait_clk(5);
        begin
            int s0;
            s0 = starts;
            req_n = 1'b0; wait_clk(REQ_MIN + 8); req_n = 1'b1;
            wait_clk(5);
            check("R4 no start in setup", starts, s0);
            check("R4 setup sticky", setup_mode, 1'b1);
        end

        do_reset();
        check("R1 reset clears setup", {sdo_oe, drdy_oe, drdy_n, setup_mode}, 4'b0010);
        set_idle(1'b0);
        acquire(16'hC0DE, 0);
        transfer(16'hC0DE, 12, 0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule